// File: doc/BRIEF.md
# Reloadable Interval Interrupt Timer

A 16-bit down-counting timer attached to a small byte-wide register bus. Software writes the reload value in two byte writes, one per half. It then writes a control byte that loads the counter and picks between a run that repeats and a single shot. While enabled and nonzero, the counter drops by one every clock. When it reaches zero it raises a timer interrupt flag. In repeat mode it then restarts from the reload value. In single-shot mode it disables itself and zeroes both the counter and the stored reload value.

A second flag records pulses from an external interrupt source. A read-only status register reports both flags. A status read acknowledges both flags at once. Any write to the reload halves or to the control register also drops a pending timer flag. The interrupt output is high while either flag is pending.

Register offsets: 0 is the low reload byte, 1 is the high reload byte, 2 is control (write), and 3 is status (read).

Top module: `interval_irq_timer`

## Requirements
- R1: After reset, `irq` is 0 and a status read at offset 3 returns 0.
- R2: A write at offset 0 sets reload bits [7:0] and a write at offset 1 sets reload bits [15:8]. Either write clears a pending timer flag, unless an expiry happens in the same cycle.
- R3: A write at offset 2 copies the reload value into the counter and clears a pending timer flag. It stores data bit 1 as enable and data bit 0 as repeat.
- R4: While enabled and nonzero, the counter decrements once per clock. With reload N > 0, the timer flag is set on the Nth clock edge after the control write.
- R5: In repeat mode the counter reloads at expiry and the flag is set again every N clocks.
- R6: In single-shot mode, expiry clears enable and zeroes both the counter and the reload value. A later enabling control write therefore raises no interrupt until the reload is rewritten.
- R7: A read of offset 3 returns bit 0 = timer flag, bit 1 = external flag, and zero in bits [7:2]. Reads of other offsets return 0.
- R8: A read strobe at offset 3 clears both flags. A read at any other offset clears neither.
- R9: `irq` is high exactly while at least one flag is pending.
- R10: A one-cycle pulse on `ext_irq_set` sets the external flag. If a set and a clear of the same flag land in the same cycle, the set wins.
- R11: With enable at 0, or with the counter at 0, the counter holds and no timer interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 2 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| ext_irq_set | input | 1 | Pulse from the external interrupt source |
| irq | output | 1 | Level interrupt request |

## Verification
The assertions assume that `rd_en` and `wr_en` are single-cycle strobes. They also assume that a read is only counted as an acknowledge when it addresses offset 3. Some properties only apply when no control write coincides with the observed cycle, because such a write reloads the counter.

The stimulus drives each strobe for exactly one clock. It keeps reload values small, so that expiries happen often. It mixes reads of other offsets with status reads to exercise the acknowledge rule. It deliberately lets external pulses, writes and status reads collide with expiries.

// File: rtl/interval_irq_timer.sv
module interval_irq_timer #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int LO_ADDR   = 0,
  parameter int HI_ADDR   = 1,
  parameter int CTL_ADDR  = 2,
  parameter int STAT_ADDR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_irq_set,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(HI_ADDR);
  localparam logic [ADDR_W-1:0] A_CT = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(STAT_ADDR);
  localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt, rld;
  logic ctl_en, ctl_rep, tmr_flag, ext_flag;

  wire wr_lo   = wr_en && (addr == A_LO);
  wire wr_hi   = wr_en && (addr == A_HI);
  wire wr_ctl  = wr_en && (addr == A_CT);
  wire stat_rd = rd_en && (addr == A_ST);
  wire run     = ctl_en && (cnt != '0);
  wire expire  = run && (cnt == ONE) && !wr_ctl;
  wire tmr_clr = wr_lo || wr_hi || wr_ctl || stat_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      rld      <= '0;
      ctl_en   <= 1'b0;
      ctl_rep  <= 1'b0;
      tmr_flag <= 1'b0;
      ext_flag <= 1'b0;
    end else begin
      if (wr_ctl) begin
        cnt     <= rld;
        ctl_en  <= wdata[1];
        ctl_rep <= wdata[0];
      end else if (expire) begin
        if (ctl_rep) begin
          cnt <= rld;
        end else begin
          cnt    <= '0;
          rld    <= '0;
          ctl_en <= 1'b0;
        end
      end else if (run) begin
        cnt <= cnt - ONE;
      end
      if (wr_lo) rld[DATA_W-1:0]     <= wdata;
      if (wr_hi) rld[CNT_W-1:DATA_W] <= wdata;
      tmr_flag <= expire || (tmr_flag && !tmr_clr);
      ext_flag <= ext_irq_set || (ext_flag && !stat_rd);
    end
  end

  assign rdata = (addr == A_ST) ? {{(DATA_W-2){1'b0}}, ext_flag, tmr_flag} : '0;
  assign irq   = tmr_flag || ext_flag;
endmodule

// File: rtl/interval_irq_timer_chk.sv
module interval_irq_timer_chk #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int CTL_ADDR  = 2,
  parameter int STAT_ADDR = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic                ext_irq_set,
  input logic [2*DATA_W-1:0] cnt,
  input logic [2*DATA_W-1:0] rld,
  input logic                ctl_en,
  input logic                ctl_rep,
  input logic                tmr_flag,
  input logic                ext_flag
);
  localparam int CNT_W = 2 * DATA_W;
  wire ctl_wr  = wr_en && (addr == ADDR_W'(CTL_ADDR));
  wire stat_rd = rd_en && (addr == ADDR_W'(STAT_ADDR));

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && cnt > CNT_W'(1) && !ctl_wr) |=> (cnt == $past(cnt) - CNT_W'(1)));

  assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !ctl_wr) |=> ($stable(cnt) && !$rose(tmr_flag)));

  assert_repeat_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && ctl_rep && cnt == CNT_W'(1) && !ctl_wr) |=> (tmr_flag && cnt == $past(rld)));

  assert_oneshot_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && !ctl_rep && cnt == CNT_W'(1) && !wr_en) |=> (tmr_flag && !ctl_en && cnt == '0 && rld == '0));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ext_irq_set) |=> !ext_flag);

  assert_ext_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq_set |=> ext_flag);
endmodule

bind interval_irq_timer interval_irq_timer_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .ext_irq_set(ext_irq_set), .cnt(cnt), .rld(rld), .ctl_en(ctl_en),
  .ctl_rep(ctl_rep), .tmr_flag(tmr_flag), .ext_flag(ext_flag)
);

// File: tb/test_interval_irq_timer.sv
`timescale 1ns/1ps
module test_interval_irq_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ext_irq_set = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] m_rld = '0, m_cnt = '0;
  bit m_en = 0, m_rep = 0, m_tf = 0, m_ef = 0;

  always #2 clk = ~clk;

  interval_irq_timer i_interval_irq_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_irq_set(ext_irq_set), .irq(irq)
  );

  function automatic logic [7:0] exp_status(input logic [1:0] a, input bit tf, input bit ef);
    return (a == 2'd3) ? {6'd0, ef, tf} : 8'd0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input bit we, input bit re, input logic [1:0] a,
                      input logic [7:0] d, input bit ext);
    bit exp_fire, clr;
    logic [15:0] n_rld;
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = d; ext_irq_set = ext;
    #1;
    chk({31'd0, irq}, {31'd0, m_tf | m_ef}, "R9");
    if (re) chk({24'd0, rdata}, {24'd0, exp_status(a, m_tf, m_ef)}, "R7");
    exp_fire = m_en && m_cnt == 16'd1 && !(we && a == 2'd2);
    clr = (we && a != 2'd3) || (re && a == 2'd3);
    n_rld = m_rld;
    if (we && a == 2'd2) begin
      m_cnt = m_rld; m_en = d[1]; m_rep = d[0];
    end else if (exp_fire) begin
      if (m_rep) m_cnt = m_rld;
      else begin m_cnt = '0; n_rld = '0; m_en = 0; end
    end else if (m_en && m_cnt != 0) m_cnt = m_cnt - 16'd1;
    if (we && a == 2'd0) n_rld[7:0] = d;
    if (we && a == 2'd1) n_rld[15:8] = d;
    m_rld = n_rld;
    m_tf = exp_fire || (m_tf && !clr);
    m_ef = ext || (m_ef && !(re && a == 2'd3));
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0; ext_irq_set = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 2'd0, 8'd0, 0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1, 0, a, d, 0);
  endtask

  task automatic rd(input logic [1:0] a);
    step(0, 1, a, 8'd0, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    addr = 2'd3;
    #1;
    chk({31'd0, irq}, 32'd0, "R1");
    chk({24'd0, rdata}, 32'd0, "R1");
    rd(2'd3);

    // R4: single shot of 5 cycles
    wr(2'd0, 8'd5); wr(2'd1, 8'd0); wr(2'd2, 8'b10);
    idle(4); chk({31'd0, irq}, 32'd0, "R4");
    idle(1); chk({31'd0, irq}, 32'd1, "R4");
    rd(2'd3); chk({31'd0, irq}, 32'd0, "R8");

    // R6: reload was zeroed, re-enable does nothing
    wr(2'd2, 8'b10); idle(20); chk({31'd0, irq}, 32'd0, "R6");

    // R5: repeat period 3
    wr(2'd0, 8'd3); wr(2'd2, 8'b11);
    idle(3); chk({31'd0, irq}, 32'd1, "R5");
    rd(2'd3); idle(1); chk({31'd0, irq}, 32'd0, "R5");
    idle(1); chk({31'd0, irq}, 32'd1, "R5");
    wr(2'd2, 8'b00); chk({31'd0, irq}, 32'd0, "R3");

    // R11: disabled
    wr(2'd0, 8'd4); wr(2'd2, 8'b01); idle(10); chk({31'd0, irq}, 32'd0, "R11");

    // R10 and R8
    step(0, 0, 2'd0, 8'd0, 1); chk({31'd0, irq}, 32'd1, "R10");
    step(0, 1, 2'd3, 8'd0, 1); chk({31'd0, irq}, 32'd1, "R10");
    rd(2'd1); chk({31'd0, irq}, 32'd1, "R8");
    rd(2'd3); chk({31'd0, irq}, 32'd0, "R8");

    // R2: byte write clears timer flag; high byte weight
    wr(2'd0, 8'd2); wr(2'd2, 8'b10); idle(2); chk({31'd0, irq}, 32'd1, "R4");
    wr(2'd1, 8'd0); chk({31'd0, irq}, 32'd0, "R2");
    wr(2'd0, 8'd2); wr(2'd1, 8'd1); wr(2'd2, 8'b10);
    idle(257); chk({31'd0, irq}, 32'd0, "R2");
    idle(1); chk({31'd0, irq}, 32'd1, "R2");
    rd(2'd3);

    // Random phase, checked against the bench model every step
    for (int i = 0; i < 6000; i++) begin
      int op;
      bit ext;
      op = $urandom_range(0, 99);
      ext = ($urandom_range(0, 29) == 0);
      if (op < 4) step(1, 0, 2'd0, 8'($urandom_range(0, 12)), ext);
      else if (op < 6) step(1, 0, 2'd1, ($urandom_range(0, 9) == 0) ? 8'd1 : 8'd0, ext);
      else if (op < 10) step(1, 0, 2'd2, 8'($urandom_range(0, 3)), ext);
      else if (op < 15) step(0, 1, 2'd3, 8'd0, ext);
      else if (op < 18) step(0, 1, 2'($urandom_range(0, 2)), 8'd0, ext);
      else step(0, 0, 2'd0, 8'd0, ext);
    end

    done = 1'b1;
    finish_run();
  end
endmodule